// File: doc/BRIEF.md
# Interrupt Enable and Mode Controller

This block holds the interrupt-enable state of an 8-bit CPU core: a primary and a backup enable flip-flop, a one-instruction delay that follows an enable event, a two-bit interrupt mode register and an 8-bit interrupt vector base register. The decoder drives one-cycle event pulses (enable, disable, set mode, return from interrupt, return from non-maskable interrupt, non-maskable interrupt taken, load base, read base) and an instruction-boundary pulse. The block reports whether maskable interrupts may be accepted and which mode is in force.

When the decoder reads the vector base into the accumulator, the block returns the base value together with the parity/overflow flag value. That flag is the backup flip-flop as it stood when the read happened. The returned triple is registered and marked by a one-cycle valid strobe. All pins are plain control and status signals with no back-pressure. The consumer takes the read result in the cycle its strobe is high, and the block never stalls.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `irq_allowed` is 0, `cur_mode` is 0, `base_out` is 0, `rd_valid` is 0, and a read returns parity flag 0 because both flip-flops are clear.
- R2: An enable pulse sets both flip-flops. `irq_allowed` stays 0 until a later cycle that carries a boundary pulse. It reads 1 from the clock edge that follows that boundary.
- R3: A boundary pulse in the same cycle as the enable pulse does not shorten the delay, so a second boundary is needed.
- R4: A disable pulse clears both flip-flops and any pending delay. It takes priority over every other event in the same cycle.
- R5: Enable takes priority over a same-cycle NMI-taken, return or boundary event.
- R6: An NMI-taken pulse clears only the primary flip-flop and leaves the backup unchanged. It takes priority over a same-cycle return.
- R7: A return from interrupt (`ev_reti`) or from NMI (`ev_retn`) copies the backup flip-flop into the primary one.
- R8: On a set-mode pulse, `mode_code` sets `cur_mode`. Bit 2 of the code is ignored. Low bits 00 or 01 give mode 0, 10 gives mode 1 and 11 gives mode 2. `cur_mode` never reads 3.
- R9: Without a set-mode pulse, `cur_mode` keeps its value.
- R10: A load pulse stores `acc_in` into the base register, and the new value shows on `base_out` after the edge.
- R11: After a read pulse, `rd_valid` is 1 for exactly one cycle. In that cycle `rd_data` holds the base value from before the edge, including when a load happens in the same cycle, and `rd_pv` holds the backup flip-flop value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_enable | input | 1 | Enable-interrupts event |
| ev_disable | input | 1 | Disable-interrupts event |
| ev_set_mode | input | 1 | Set-mode event |
| mode_code | input | 3 | Opcode mode field |
| ev_reti | input | 1 | Return from maskable interrupt |
| ev_retn | input | 1 | Return from non-maskable interrupt |
| ev_nmi_take | input | 1 | Non-maskable interrupt accepted |
| ev_load_base | input | 1 | Load base register from accumulator |
| acc_in | input | 8 | Accumulator value |
| ev_read_base | input | 1 | Read base register into accumulator |
| ev_boundary | input | 1 | Instruction boundary |
| irq_allowed | output | 1 | Maskable interrupts may be accepted |
| cur_mode | output | 2 | Current interrupt mode (0, 1, 2) |
| base_out | output | 8 | Vector base register |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 8 | Base value returned by a read |
| rd_pv | output | 1 | Parity/overflow flag value for the read |

## Verification
The bench targets four corner cases.

- **Boundary in the enable cycle.** A design that treats this boundary as ending the delay opens interrupts one instruction early.
- **Disable beside enable.** The bench pulses disable and enable together, and also disables while an enable is pending. A wrong priority leaves interrupts armed.
- **NMI taken, then return.** A design that clears the backup flip-flop on NMI entry returns with `rd_pv` and `irq_allowed` low.
- **Mode codes and reads.** The bench drives all eight mode codes, so a decode that reads bit 2 shows mode errors. It also issues a read in the same cycle as a load, which exposes a read path that forwards the new value.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    IM_ZERO = 2'd0,
    IM_ONE  = 2'd1,
    IM_TWO  = 2'd2
  } irq_mode_e;

  // Only the two low bits of the field select the mode.
  function automatic irq_mode_e decode_mode(input logic [1:0] lo);
    irq_mode_e m;
    if (!lo[1])     m = IM_ZERO;
    else if (lo[0]) m = IM_TWO;
    else            m = IM_ONE;
    return m;
  endfunction

endpackage

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_enable,
  input  logic ev_disable,
  input  logic ev_ret,
  input  logic ev_nmi_take,
  input  logic ev_boundary,
  output logic iff1,
  output logic iff2,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      pending <= 1'b0;
    end else if (ev_disable) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      pending <= 1'b0;
    end else if (ev_enable) begin
      iff1    <= 1'b1;
      iff2    <= 1'b1;
      pending <= 1'b1;
    end else begin
      if (ev_nmi_take)  iff1 <= 1'b0;
      else if (ev_ret)  iff1 <= iff2;
      if (ev_boundary)  pending <= 1'b0;
    end
  end

  // R4
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_disable |=> (!iff1 && !iff2 && !pending));

  // R2
  enable_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_enable && !ev_disable) |=> (iff1 && iff2 && pending));

  // R6
  nmi_keeps_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nmi_take && !ev_enable && !ev_disable) |=> (!iff1 && iff2 == $past(iff2)));

  // R7
  ret_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ret && !ev_nmi_take && !ev_enable && !ev_disable) |=> (iff1 == $past(iff2)));

endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_ctrl_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_set_mode,
  input  logic [CODE_W-1:0] mode_code,
  output logic [1:0]        cur_mode
);

  irq_mode_e mode_q;
  logic      unused_code_hi;

  assign unused_code_hi = ^mode_code[CODE_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= IM_ZERO;
    else if (ev_set_mode) mode_q <= decode_mode(mode_code[1:0]);
  end

  assign cur_mode = mode_q;

  // R8
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode != 2'd3);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_set_mode |=> $stable(cur_mode));

endmodule

// File: rtl/irq_base_reg.sv
module irq_base_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load_base,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              ev_read_base,
  input  logic              backup_ff,
  output logic [DATA_W-1:0] base_out,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pv
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_out <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_pv    <= 1'b0;
    end else begin
      if (ev_load_base) base_out <= acc_in;
      rd_valid <= ev_read_base;
      if (ev_read_base) begin
        rd_data <= base_out;
        rd_pv   <= backup_ff;
      end
    end
  end

  // R10
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_base |=> (base_out == $past(acc_in)));

  // R11
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_base |=> (rd_valid && rd_data == $past(base_out)));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_enable,
  input  logic              ev_disable,
  input  logic              ev_set_mode,
  input  logic [CODE_W-1:0] mode_code,
  input  logic              ev_reti,
  input  logic              ev_retn,
  input  logic              ev_nmi_take,
  input  logic              ev_load_base,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              ev_read_base,
  input  logic              ev_boundary,
  output logic              irq_allowed,
  output logic [1:0]        cur_mode,
  output logic [DATA_W-1:0] base_out,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pv
);

  logic iff1, iff2, pending;

  irq_enable_ff u_ff (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_enable   (ev_enable),
    .ev_disable  (ev_disable),
    .ev_ret      (ev_reti | ev_retn),
    .ev_nmi_take (ev_nmi_take),
    .ev_boundary (ev_boundary),
    .iff1        (iff1),
    .iff2        (iff2),
    .pending     (pending)
  );

  irq_mode_reg #(.CODE_W(CODE_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_set_mode (ev_set_mode),
    .mode_code   (mode_code),
    .cur_mode    (cur_mode)
  );

  irq_base_reg #(.DATA_W(DATA_W)) u_base (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_load_base (ev_load_base),
    .acc_in       (acc_in),
    .ev_read_base (ev_read_base),
    .backup_ff    (iff2),
    .base_out     (base_out),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_pv        (rd_pv)
  );

  assign irq_allowed = iff1 & ~pending;

  // R2
  enable_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_enable && !ev_disable) |=> !irq_allowed);

  // R3
  same_cycle_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_enable && ev_boundary && !ev_disable) |=> !irq_allowed);

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_enable = 0, ev_disable = 0, ev_set_mode = 0;
  logic [2:0] mode_code = 0;
  logic       ev_reti = 0, ev_retn = 0, ev_nmi_take = 0;
  logic       ev_load_base = 0, ev_read_base = 0, ev_boundary = 0;
  logic [7:0] acc_in = 0;
  logic       irq_allowed, rd_valid, rd_pv;
  logic [1:0] cur_mode;
  logic [7:0] base_out, rd_data;

  int errors = 0;
  int checks = 0;

  // Reference state after the most recent edge.
  logic m_i1 = 0, m_i2 = 0, m_pend = 0, m_rv = 0, m_pv = 0;
  logic [1:0] m_mode = 0;
  logic [7:0] m_base = 0, m_rd = 0;

  always #5 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_enable(ev_enable), .ev_disable(ev_disable),
    .ev_set_mode(ev_set_mode), .mode_code(mode_code), .ev_reti(ev_reti),
    .ev_retn(ev_retn), .ev_nmi_take(ev_nmi_take), .ev_load_base(ev_load_base),
    .acc_in(acc_in), .ev_read_base(ev_read_base), .ev_boundary(ev_boundary),
    .irq_allowed(irq_allowed), .cur_mode(cur_mode), .base_out(base_out),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_pv(rd_pv)
  );

  function automatic logic [1:0] exp_mode(input logic [2:0] c);
    case (c[1:0])
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Advance the reference through the edge that applies the current inputs.
  task automatic model_step();
    logic o_i2;
    logic [7:0] o_base;
    o_i2 = m_i2;
    o_base = m_base;
    if (ev_disable) begin
      m_i1 = 0; m_i2 = 0; m_pend = 0;
    end else if (ev_enable) begin
      m_i1 = 1; m_i2 = 1; m_pend = 1;
    end else begin
      if (ev_nmi_take) m_i1 = 0;
      else if (ev_reti || ev_retn) m_i1 = o_i2;
      if (ev_boundary) m_pend = 0;
    end
    if (ev_set_mode) m_mode = exp_mode(mode_code);
    if (ev_load_base) m_base = acc_in;
    m_rv = ev_read_base;
    if (ev_read_base) begin
      m_rd = o_base;
      m_pv = o_i2;
    end
  endtask

  task automatic clear_ev();
    ev_enable = 0; ev_disable = 0; ev_set_mode = 0; ev_reti = 0; ev_retn = 0;
    ev_nmi_take = 0; ev_load_base = 0; ev_read_base = 0; ev_boundary = 0;
  endtask

  // Inputs already driven; model, cross the edge, then compare at the negedge.
  task automatic cyc();
    model_step();
    @(negedge clk);
    chk("R2 irq_allowed", irq_allowed, m_i1 & ~m_pend);
    chk("R8 cur_mode", cur_mode, m_mode);
    chk("R10 base_out", base_out, m_base);
    chk("R11 rd_valid", rd_valid, m_rv);
    if (m_rv) begin
      chk("R11 rd_data", rd_data, m_rd);
      chk("R11 rd_pv", rd_pv, m_pv);
    end
    clear_ev();
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq_allowed", irq_allowed, 0);
    chk("R1 cur_mode", cur_mode, 0);
    chk("R1 base_out", base_out, 0);
    chk("R1 rd_valid", rd_valid, 0);
    ev_read_base = 1; cyc();
    chk("R1 rd_pv after reset", rd_pv, 0);

    // R3: boundary in the enable cycle, then the real boundary
    ev_enable = 1; ev_boundary = 1; cyc();
    chk("R3 still blocked", irq_allowed, 0);
    cyc();
    chk("R2 blocked without boundary", irq_allowed, 0);
    ev_boundary = 1; cyc();
    chk("R2 open after boundary", irq_allowed, 1);

    // R6/R7: NMI taken then return restores
    ev_nmi_take = 1; ev_retn = 1; cyc();
    chk("R6 nmi clears primary", irq_allowed, 0);
    ev_read_base = 1; cyc();
    chk("R6 backup kept", rd_pv, 1);
    ev_reti = 1; cyc();
    chk("R7 return restores", irq_allowed, 1);

    // R4: disable together with enable, and while pending
    ev_disable = 1; ev_enable = 1; cyc();
    ev_boundary = 1; cyc();
    chk("R4 disable beats enable", irq_allowed, 0);
    ev_enable = 1; cyc();
    ev_disable = 1; cyc();
    ev_reti = 1; ev_boundary = 1; cyc();
    chk("R4 pending cancelled", irq_allowed, 0);

    // R5: enable beats nmi in same cycle
    ev_enable = 1; ev_nmi_take = 1; cyc();
    ev_boundary = 1; cyc();
    chk("R5 enable priority", irq_allowed, 1);

    // R8: all eight codes
    for (int c = 0; c < 8; c++) begin
      ev_set_mode = 1; mode_code = 3'(c); cyc();
      chk("R8 mode decode", cur_mode, exp_mode(3'(c)));
    end
    // R9 hold
    mode_code = 3'd3; cyc();
    chk("R9 mode held", cur_mode, exp_mode(3'd7));

    // R10/R11: read with load in same cycle
    ev_load_base = 1; acc_in = 8'h5A; cyc();
    ev_load_base = 1; acc_in = 8'hC3; ev_read_base = 1; cyc();
    chk("R11 old base returned", rd_data, 8'h5A);
    chk("R10 new base", base_out, 8'hC3);
    cyc();
    chk("R11 single strobe", rd_valid, 0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      ev_enable    = ($urandom % 8) == 0;
      ev_disable   = ($urandom % 12) == 0;
      ev_set_mode  = ($urandom % 6) == 0;
      mode_code    = 3'($urandom);
      ev_reti      = ($urandom % 10) == 0;
      ev_retn      = ($urandom % 10) == 0;
      ev_nmi_take  = ($urandom % 10) == 0;
      ev_load_base = ($urandom % 5) == 0;
      acc_in       = 8'($urandom);
      ev_read_base = ($urandom % 4) == 0;
      ev_boundary  = ($urandom % 3) == 0;
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule